// File: doc/BRIEF.md
# Parallel Configuration Host Controller

This block is the host side of a byte-wide passive configuration load. It pulls the program line low to reset one programmable device, or a chain of them, then waits for the shared health line to come back high. It then streams bitstream bytes from a valid/ready source onto an 8-bit bus and marks each byte with one write-clock pulse. The chain hands over from one device to the next by itself, so the host sends a single unbroken byte stream and never knows where one device ends. When the shared loaded line rises, the whole chain has entered user mode. The block then stops clocking and reports done.

A failed attempt raises a one-cycle error pulse and tells the byte source to rewind. An attempt fails when the health line drops, when it does not rise in time, or when the loaded line stays low after the stream and a few extra clocks. The retry then either pulses the program line again, or waits for self-restarting devices to release the health line and resends at once. After a set number of failed attempts the block stops with a fatal status.

Top module: `cfg_host`

## Requirements
- R1: While reset is asserted and just after it: prog_n_o is 1, wr_clk_o is 0, and in_ready, busy, done, error, fatal and rewind are 0.
- R2: A start pulse accepted while idle, done or fatal gives a one-cycle rewind pulse. It then drives prog_n_o low for exactly PULSE_CYC cycles before driving it high again. start has no effect while busy.
- R3: After prog_n_o rises, no byte is accepted (in_ready stays 0) until the synchronized health_n_i reads 1. If it does not read 1 within STATUS_TO cycles, the attempt fails and a program pulse follows.
- R4: Each accepted byte produces exactly one wr_clk_o pulse. The byte sits on wr_data_o for at least CLK_DIV cycles with the clock low, and the clock is then high for CLK_DIV cycles. wr_data_o changes only while wr_clk_o is low.
- R5: Bytes reach wr_data_o in source order as one continuous stream. No marker and no wait other than for in_valid is inserted, whichever chained device is receiving.
- R6: When the synchronized loaded_i reads 1 during transfer, the block enters done: wr_clk_o stops low, in_ready is 0 and done is 1.
- R7: After the byte flagged in_last, FLUSH_CYC further write-clock pulses follow with the data held. If loaded_i is still 0 after them, the attempt fails and a program pulse follows.
- R8: health_n_i reading 0 during transfer or flush fails the attempt (error is a one-cycle pulse). With restart_self at 0 the retry starts with a program pulse.
- R9: With restart_self at 1, a health_n_i failure gives no program pulse. The block waits up to STATUS_TO cycles for health_n_i to read 1, then rewinds and resends from the first byte. If it times out, that is a failure retried with a program pulse.
- R10: The MAX_TRIES-th failed attempt ends in fatal: prog_n_o high, clock low, done 0. fatal holds until a new start.
- R11: If health_n_i reads 0 in the same cycle that loaded_i reads 1, the failure wins and done is not reported.
- R12: health_n_i and loaded_i pass through SYNC_STAGES flops. A change takes effect in the controller SYNC_STAGES+1 clock edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a fresh load (idle, done or fatal only) |
| restart_self | input | 1 | 1: devices restart themselves after an error; 0: retry with a program pulse |
| in_data | input | DATA_W | Bitstream byte from the source |
| in_valid | input | 1 | in_data holds a byte |
| in_last | input | 1 | Current byte is the final byte of the bitstream |
| in_ready | output | 1 | Byte is taken on this clock edge when in_valid is 1 |
| rewind | output | 1 | One-cycle request to restart the source at its first byte |
| prog_n_o | output | 1 | Active-low program/reset line to the chain |
| wr_clk_o | output | 1 | Byte write clock to the chain |
| wr_data_o | output | DATA_W | Byte bus to the chain |
| health_n_i | input | 1 | Shared open-drain status line, 0 = error or reset |
| loaded_i | input | 1 | Shared open-drain line, 1 = whole chain configured |
| busy | output | 1 | A load or retry is in progress |
| done | output | 1 | Chain configured |
| error | output | 1 | One-cycle pulse per failed attempt |
| fatal | output | 1 | Retries used up |

## Verification
The failure and completion detectors can fire in the same cycle. The bench's chain model drops the health line and raises the loaded line on the same negative edge, at the last byte's write clock. Both reach the controller through the synchronizer in the same cycle. The reference model says the error pulse and a program pulse must follow with done held low, and the final counts of error pulses and program pulses confirm that only one retry was taken.

// File: rtl/cfgh_pkg.sv
package cfgh_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_WAIT,
        ST_SEND,
        ST_FLUSH,
        ST_DONE,
        ST_RECOV,
        ST_FAIL
    } cfgh_state_e;
endpackage

// File: rtl/cfgh_sync.sv
module cfgh_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar g = 0; g < STAGES; g++) begin : g_stg
        logic [WIDTH-1:0] r;
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= '0;
                else        r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= '0;
                else        r <= g_stg[g-1].r;
            end
        end
    end

    assign q = g_stg[STAGES-1].r;
endmodule

// File: rtl/cfgh_seq.sv
module cfgh_seq
    import cfgh_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CLK_DIV   = 2,
    parameter int PULSE_CYC = 100,
    parameter int STATUS_TO = 30000,
    parameter int FLUSH_CYC = 64,
    parameter int MAX_TRIES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              restart_self,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic              rewind,
    input  logic              ns_ok,
    input  logic              cd_ok,
    output logic              prog_n_o,
    output logic              wr_clk_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              fatal
);
    localparam int MAXV = (STATUS_TO > PULSE_CYC)
                        ? ((STATUS_TO > CLK_DIV) ? STATUS_TO : CLK_DIV)
                        : ((PULSE_CYC > CLK_DIV) ? PULSE_CYC : CLK_DIV);
    localparam int CW = $clog2(MAXV + 1);
    localparam int FW = $clog2(FLUSH_CYC + 2);
    localparam int TW = $clog2(MAX_TRIES + 1);

    typedef struct packed {
        cfgh_state_e       st;
        logic [CW-1:0]     cnt;
        logic [FW-1:0]     rem;
        logic [TW-1:0]     tries;
        logic              have;
        logic              hi;
        logic              last;
        logic              prog_n;
        logic              wclk;
        logic              err;
        logic              rew;
        logic [DATA_W-1:0] data;
    } regs_t;

    regs_t r_q, r_d;
    logic  fail_ns, fail_hard;

    always_comb begin
        r_d       = r_q;
        r_d.err   = 1'b0;
        r_d.rew   = 1'b0;
        fail_ns   = 1'b0;
        fail_hard = 1'b0;
        unique case (r_q.st)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) begin
                    r_d.tries  = '0;
                    r_d.rew    = 1'b1;
                    r_d.st     = ST_PULSE;
                    r_d.prog_n = 1'b0;
                    r_d.cnt    = CW'(PULSE_CYC - 1);
                end
            end
            ST_PULSE: begin
                if (r_q.cnt == '0) begin
                    r_d.prog_n = 1'b1;
                    r_d.st     = ST_WAIT;
                    r_d.cnt    = CW'(STATUS_TO - 1);
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_WAIT, ST_RECOV: begin
                if (ns_ok) begin
                    r_d.st   = ST_SEND;
                    r_d.have = 1'b0;
                    r_d.hi   = 1'b0;
                end else if (r_q.cnt == '0) begin
                    fail_hard = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_SEND, ST_FLUSH: begin
                if (!ns_ok) begin
                    fail_ns = 1'b1;
                end else if (cd_ok) begin
                    r_d.st   = ST_DONE;
                    r_d.wclk = 1'b0;
                    r_d.hi   = 1'b0;
                    r_d.have = 1'b0;
                end else if (r_q.st == ST_SEND && !r_q.have) begin
                    if (in_valid) begin
                        r_d.have = 1'b1;
                        r_d.data = in_data;
                        r_d.last = in_last;
                        r_d.cnt  = CW'(CLK_DIV - 1);
                    end
                end else if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else if (!r_q.hi) begin
                    if (r_q.st == ST_FLUSH && r_q.rem == '0) begin
                        fail_hard = 1'b1;
                    end else begin
                        r_d.hi   = 1'b1;
                        r_d.wclk = 1'b1;
                        r_d.cnt  = CW'(CLK_DIV - 1);
                    end
                end else begin
                    r_d.hi   = 1'b0;
                    r_d.wclk = 1'b0;
                    r_d.cnt  = CW'(CLK_DIV - 1);
                    if (r_q.st == ST_FLUSH) begin
                        r_d.rem = r_q.rem - 1'b1;
                    end else begin
                        r_d.have = 1'b0;
                        if (r_q.last) begin
                            r_d.st  = ST_FLUSH;
                            r_d.rem = FW'(FLUSH_CYC);
                        end
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (fail_ns || fail_hard) begin
            r_d.err  = 1'b1;
            r_d.wclk = 1'b0;
            r_d.hi   = 1'b0;
            r_d.have = 1'b0;
            if (r_q.tries == TW'(MAX_TRIES - 1)) begin
                r_d.st     = ST_FAIL;
                r_d.prog_n = 1'b1;
            end else begin
                r_d.tries = r_q.tries + 1'b1;
                r_d.rew   = 1'b1;
                if (fail_ns && restart_self) begin
                    r_d.st  = ST_RECOV;
                    r_d.cnt = CW'(STATUS_TO - 1);
                end else begin
                    r_d.st     = ST_PULSE;
                    r_d.prog_n = 1'b0;
                    r_d.cnt    = CW'(PULSE_CYC - 1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= ST_IDLE;
            r_q.prog_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready  = (r_q.st == ST_SEND) && !r_q.have && ns_ok && !cd_ok;
    assign rewind    = r_q.rew;
    assign prog_n_o  = r_q.prog_n;
    assign wr_clk_o  = r_q.wclk;
    assign wr_data_o = r_q.data;
    assign error     = r_q.err;
    assign done      = (r_q.st == ST_DONE);
    assign fatal     = (r_q.st == ST_FAIL);
    assign busy      = !(r_q.st == ST_IDLE || r_q.st == ST_DONE || r_q.st == ST_FAIL);
endmodule

// File: rtl/cfg_host.sv
module cfg_host #(
    parameter int DATA_W      = 8,
    parameter int CLK_DIV     = 2,
    parameter int PULSE_CYC   = 100,
    parameter int STATUS_TO   = 30000,
    parameter int FLUSH_CYC   = 64,
    parameter int MAX_TRIES   = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              restart_self,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic              rewind,
    output logic              prog_n_o,
    output logic              wr_clk_o,
    output logic [DATA_W-1:0] wr_data_o,
    input  logic              health_n_i,
    input  logic              loaded_i,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              fatal
);
    logic [1:0] line_s;

    cfgh_sync #(
        .WIDTH (2),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({loaded_i, health_n_i}),
        .q    (line_s)
    );

    cfgh_seq #(
        .DATA_W   (DATA_W),
        .CLK_DIV  (CLK_DIV),
        .PULSE_CYC(PULSE_CYC),
        .STATUS_TO(STATUS_TO),
        .FLUSH_CYC(FLUSH_CYC),
        .MAX_TRIES(MAX_TRIES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .restart_self(restart_self),
        .in_data     (in_data),
        .in_valid    (in_valid),
        .in_last     (in_last),
        .in_ready    (in_ready),
        .rewind      (rewind),
        .ns_ok       (line_s[0]),
        .cd_ok       (line_s[1]),
        .prog_n_o    (prog_n_o),
        .wr_clk_o    (wr_clk_o),
        .wr_data_o   (wr_data_o),
        .busy        (busy),
        .done        (done),
        .error       (error),
        .fatal       (fatal)
    );
endmodule

// File: rtl/cfg_host_chk.sv
module cfg_host_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              in_ready,
    input logic              prog_n_o,
    input logic              wr_clk_o,
    input logic [DATA_W-1:0] wr_data_o,
    input logic              busy,
    input logic              done,
    input logic              error,
    input logic              fatal
);
    a_r1_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done, fatal}));

    a_r2_prog_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_n_o |-> (busy && !wr_clk_o && !in_ready));

    a_r3_ready_after_prog: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (prog_n_o && busy));

    a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clk_o |-> $stable(wr_data_o));

    a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!wr_clk_o && !in_ready));

    a_r8_error_single: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error);

    a_r10_fatal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fatal && !start) |=> fatal);
endmodule

bind cfg_host cfg_host_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/cfg_host_test.sv
module cfg_host_test;
    localparam int D  = 2;
    localparam int PC = 6;
    localparam int S  = 40;
    localparam int FL = 3;
    localparam int MT = 3;

    localparam int M_IDLE = 0, M_PUL = 1, M_WT = 2, M_SND = 3;
    localparam int M_FL = 4, M_DN = 5, M_RC = 6, M_FT = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       restart_self = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       health = 1'b0;
    logic       loaded = 1'b0;
    logic       in_ready, rewind, prog_n_o, wr_clk_o, busy, done, error, fatal;
    logic [7:0] wr_data_o;

    always #10 clk = ~clk;

    cfg_host #(
        .DATA_W(8), .CLK_DIV(D), .PULSE_CYC(PC), .STATUS_TO(S),
        .FLUSH_CYC(FL), .MAX_TRIES(MT), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .restart_self(restart_self),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
        .in_ready(in_ready), .rewind(rewind), .prog_n_o(prog_n_o),
        .wr_clk_o(wr_clk_o), .wr_data_o(wr_data_o), .health_n_i(health),
        .loaded_i(loaded), .busy(busy), .done(done), .error(error), .fatal(fatal)
    );

    int checks = 0;
    int nerr = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // stimulus settings
    logic [7:0] src [32];
    int  nbytes = 10;
    int  need = 10;
    int  rise_dly = 5;
    int  inj_at = 0;
    bit  inj_armed = 0;
    bit  inj_cd = 0;
    int  hold = 12;
    bit  gaps_on = 1;
    int  progs = 0;
    int  err_pulses = 0;
    int  got = 0;
    int  ld_cyc = 0;
    int  done_cyc = 0;

    initial begin
        for (int i = 0; i < 32; i++) src[i] = 8'(i * 37 + 11);
    end

    always @(posedge clk) cyc <= cyc + 1;

    // reference model: state advanced on every clock edge
    int   mst, mt, mrem, mtries;
    bit   mhave, mlast, mprog, mwclk, merr, mrew;
    bit   ms0, ms1, mc0, mc1;
    logic [7:0] mdata;

    task m_fail(input bit from_health);
        merr  = 1;
        mwclk = 0;
        mhave = 0;
        if (mtries == MT - 1) begin
            mst = M_FT;
            mprog = 1;
        end else begin
            mtries++;
            mrew = 1;
            if (from_health && restart_self) begin
                mst = M_RC; mt = 0;
            end else begin
                mst = M_PUL; mprog = 0; mt = 0;
            end
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mst = M_IDLE; mt = 0; mrem = 0; mtries = 0;
            mhave = 0; mlast = 0; mprog = 1; mwclk = 0; merr = 0; mrew = 0;
            ms0 = 0; ms1 = 0; mc0 = 0; mc1 = 0; mdata = 8'h00;
        end else begin
            bit h, c;
            h = ms1; c = mc1;
            ms1 = ms0; ms0 = health;
            mc1 = mc0; mc0 = loaded;
            merr = 0; mrew = 0;
            case (mst)
                M_IDLE, M_DN, M_FT: if (start) begin
                    mtries = 0; mrew = 1; mst = M_PUL; mprog = 0; mt = 0;
                end
                M_PUL: begin
                    mt++;
                    if (mt == PC) begin mprog = 1; mst = M_WT; mt = 0; end
                end
                M_WT, M_RC: begin
                    mt++;
                    if (h) begin mst = M_SND; mhave = 0; end
                    else if (mt == S) m_fail(0);
                end
                M_SND: begin
                    if (!h) m_fail(1);
                    else if (c) begin mst = M_DN; mwclk = 0; mhave = 0; end
                    else if (!mhave) begin
                        if (in_valid) begin
                            mhave = 1; mt = 0; mdata = in_data; mlast = in_last;
                        end
                    end else begin
                        mt++;
                        mwclk = (mt >= D && mt < 2 * D);
                        if (mt == 2 * D) begin
                            mhave = 0;
                            if (mlast) begin mst = M_FL; mrem = FL; mt = 0; end
                        end
                    end
                end
                M_FL: begin
                    if (!h) m_fail(1);
                    else if (c) begin mst = M_DN; mwclk = 0; end
                    else begin
                        mt++;
                        if (mt == D && mrem == 0) m_fail(0);
                        else begin
                            mwclk = (mt >= D && mt < 2 * D);
                            if (mt == 2 * D) begin mrem--; mt = 0; end
                        end
                    end
                end
                default: mst = M_IDLE;
            endcase
        end
    end

    // compare against the model every cycle, away from the active edge
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            bit mrdy, mbusy;
            mrdy  = (mst == M_SND) && !mhave && ms1 && !mc1;
            mbusy = !(mst == M_IDLE || mst == M_DN || mst == M_FT);
            chk(prog_n_o == mprog, "R2", "prog_n_o", prog_n_o, mprog);
            chk(wr_clk_o == mwclk, "R4", "wr_clk_o", wr_clk_o, mwclk);
            chk(wr_data_o == mdata, "R5", "wr_data_o", wr_data_o, mdata);
            chk(in_ready == mrdy, "R3", "in_ready", in_ready, mrdy);
            chk(busy == mbusy, "R1", "busy", busy, mbusy);
            chk(done == (mst == M_DN), "R6", "done", done, mst == M_DN);
            chk(error == merr, "R8", "error", error, merr);
            chk(fatal == (mst == M_FT), "R10", "fatal", fatal, mst == M_FT);
            chk(rewind == mrew, "R9", "rewind", rewind, mrew);
            if (done && done_cyc == 0) done_cyc = cyc;
        end
    end

    // byte source
    initial begin
        int  ptr;
        bit  took;
        ptr = 0; took = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                ptr = 0; took = 0; in_valid = 0;
            end else begin
                if (took) ptr++;
                if (rewind) ptr = 0;
                in_valid = (ptr < nbytes) && !(gaps_on && (cyc % 5 == 3));
                in_data  = src[ptr % 32];
                in_last  = (ptr == nbytes - 1);
                took     = in_valid && in_ready;
            end
        end
    end

    // device chain model: shared health and loaded lines
    initial begin
        int  rel;
        bit  prev_w, prev_p;
        rel = -1; prev_w = 0; prev_p = 1;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                health = 0; loaded = 0; got = 0; prev_w = 0; prev_p = 1;
            end else begin
                if (error) err_pulses++;
                if (prev_p && !prog_n_o) progs++;
                prev_p = prog_n_o;
                if (!prog_n_o) begin
                    health = 0; loaded = 0; got = 0; rel = rise_dly;
                end else if (!health && rel >= 0) begin
                    if (rel == 0) begin health = 1; got = 0; rel = -1; end
                    else rel--;
                end else if (health && wr_clk_o && !prev_w) begin
                    got++;
                    if (got <= nbytes)
                        chk(wr_data_o == src[got-1], "R5", "byte order",
                            wr_data_o, src[got-1]);
                    if (inj_armed && got == inj_at) begin
                        inj_armed = 0;
                        health = 0;
                        rel = restart_self ? hold : -1;
                        if (inj_cd) begin loaded = 1; ld_cyc = cyc; end
                    end else if (got == need) begin
                        loaded = 1; ld_cyc = cyc;
                    end
                end
                prev_w = wr_clk_o;
            end
        end
    end

    task automatic run_load();
        progs = 0; err_pulses = 0; done_cyc = 0;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        for (int i = 0; i < 6000 && busy; i++) @(negedge clk);
        chk(!busy, "R10", "load finished", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(prog_n_o == 1, "R1", "reset prog_n_o", prog_n_o, 1);
        chk(wr_clk_o == 0, "R1", "reset wr_clk_o", wr_clk_o, 0);
        chk(!busy && !done && !fatal && !error && !in_ready && !rewind,
            "R1", "reset status", {busy, done, fatal, error, in_ready, rewind}, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);

        // normal load, start while busy ignored
        progs = 0; err_pulses = 0; done_cyc = 0;
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        repeat (25) @(negedge clk);
        start = 1;
        @(negedge clk) start = 0;
        for (int i = 0; i < 6000 && busy; i++) @(negedge clk);
        chk(done == 1, "R6", "done after load", done, 1);
        chk(got == 10, "R5", "bytes delivered", got, 10);
        chk(progs == 1, "R2", "single program pulse", progs, 1);
        chk(done_cyc - ld_cyc == 3, "R12", "loaded latency", done_cyc - ld_cyc, 3);

        // stream too short: flush then failure, retries to fatal
        need = 14;
        run_load();
        chk(fatal == 1, "R10", "fatal after retries", fatal, 1);
        chk(err_pulses == MT, "R7", "flush failures", err_pulses, MT);
        chk(got == 10 + FL, "R7", "flush pulses", got, 10 + FL);
        chk(progs == MT, "R7", "program pulses", progs, MT);

        // health drop, program-pulse recovery (start from fatal)
        need = 10; inj_at = 4; inj_armed = 1; restart_self = 0;
        run_load();
        chk(done == 1, "R8", "recovered", done, 1);
        chk(err_pulses == 1, "R8", "one error", err_pulses, 1);
        chk(progs == 2, "R8", "program pulses", progs, 2);

        // health drop, self-restart recovery
        inj_at = 3; inj_armed = 1; restart_self = 1; hold = 12;
        run_load();
        chk(done == 1, "R9", "self restart done", done, 1);
        chk(progs == 1, "R9", "no extra program pulse", progs, 1);
        chk(err_pulses == 1, "R9", "one error", err_pulses, 1);

        // self-restart wait times out
        inj_at = 5; inj_armed = 1; hold = 60;
        run_load();
        chk(done == 1, "R9", "done after timeout retry", done, 1);
        chk(err_pulses == 2, "R9", "errors", err_pulses, 2);
        chk(progs == 2, "R9", "program pulses", progs, 2);
        restart_self = 0;

        // health never rises
        rise_dly = -1;
        run_load();
        chk(fatal == 1, "R3", "fatal on no health", fatal, 1);
        chk(err_pulses == MT, "R3", "timeouts", err_pulses, MT);
        chk(got == 0, "R3", "no bytes clocked", got, 0);
        rise_dly = 5;
        gaps_on = 0;
        run_load();
        chk(done == 1, "R10", "restart from fatal", done, 1);

        // loaded and health-fail in the same cycle
        inj_at = 10; inj_armed = 1; inj_cd = 1;
        run_load();
        chk(err_pulses == 1, "R11", "failure wins", err_pulses, 1);
        chk(progs == 2, "R11", "retry taken", progs, 2);
        chk(done == 1, "R11", "second attempt done", done, 1);
        inj_cd = 0;

        $display("CHECKS %0d ERRORS %0d", checks, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, nerr);
        $finish;
    end
endmodule